// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between the interrupt sources of a system and one processor core. It holds a 32-bit presentation word and drives a single interrupt line. The word carries the core's current priority in bits 31:24 and the number of the source waiting for service in bits 23:0. A source field of zero means that nothing is waiting. Next to the word the block keeps a hidden pending priority and an inter-processor request priority. For all priorities, a lower number is more favoured, and 0xFF means "none".

Sources offer requests as a number and a priority. The block keeps at most one waiting request. A request that loses out, or that is pushed aside by a better one, is handed back to its source on a reject strobe; it is never queued. The core uses five strobes:
- a current-priority write;
- an inter-processor priority write;
- an accept, which returns the word and promotes the pending priority;
- an end-of-interrupt write, which is forwarded to the source side;
- an incoming request from a source.

When the block becomes free again it asks the sources to resend. Reserved source number 2 marks an inter-processor request. Such a request has no owner among the sources, so it is never rejected back.

Top module: `irq_presenter`

## Requirements
- R1: After reset the word `xirr_o` is 0, `irq_o` is low, `ipi_prio_o` is 0xFF, the pending priority is 0xFF, and no reject, EOI or resend strobe is active.
- R2: An accept returns `xirr_o` as it stands in the accept cycle. After the edge, bits 31:24 hold the former pending priority, bits 23:0 are 0, `irq_o` is low and the pending priority is 0xFF.
- R3: A request is rejected when its priority is greater than or equal to bits 31:24, or when a request is already waiting at a priority less than or equal to it. The reject carries the request's own number, and the word is left unchanged.
- R4: A request that is not rejected is latched into bits 23:0 and raises `irq_o`. A waiting request from a source that it displaces is rejected with that source's number. A displaced inter-processor request produces no reject.
- R5: An inter-processor priority write always updates `ipi_prio_o`. When the new value is below bits 31:24, and nothing is waiting at a priority less than or equal to it, bits 23:0 become 2, the pending priority becomes the new value, `irq_o` rises, and any displaced source request is rejected.
- R6: A current-priority write below the old value clears a waiting request whose pending priority is greater than or equal to the new value. The source field goes to 0, the pending priority to 0xFF and `irq_o` low, and the request is rejected if a source owns it. A request with a pending priority below the new value stays.
- R7: A current-priority write equal to or above the old value, with nothing waiting, pulses `resend_o`.
- R8: An EOI write copies its bits 31:24 into bits 31:24 of the word and pulses `eoi_valid_o` with its bits 23:0 on `eoi_src_o`. If nothing is waiting, it also pulses `resend_o`.
- R9: Every resend first takes the inter-processor request, with the same effect as in R5, when `ipi_prio_o` is below the newly written current priority.
- R10: At most one of the five operation strobes is high in any cycle, and a source request never carries source number 0.
- R11: Reject, EOI and resend outputs are single-cycle strobes. They appear in the cycle after the operation that causes them, and the word changes at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Source request strobe |
| req_src_i | input | 24 | Requesting source number |
| req_prio_i | input | 8 | Requesting priority |
| cppr_wr_i | input | 1 | Current-priority write strobe |
| cppr_data_i | input | 8 | New current priority |
| ipi_wr_i | input | 1 | Inter-processor priority write strobe |
| ipi_data_i | input | 8 | New inter-processor priority |
| accept_i | input | 1 | Accept strobe; the word is read in this cycle |
| eoi_wr_i | input | 1 | End-of-interrupt write strobe |
| eoi_data_i | input | 32 | Priority (31:24) and finished source (23:0) |
| xirr_o | output | 32 | Presentation word |
| ipi_prio_o | output | 8 | Inter-processor priority register |
| irq_o | output | 1 | Interrupt line to the core |
| reject_valid_o | output | 1 | Reject strobe |
| reject_src_o | output | 24 | Rejected source number |
| eoi_valid_o | output | 1 | EOI notice strobe |
| eoi_src_o | output | 24 | Source number for the EOI notice |
| resend_o | output | 1 | Resend request to the sources |

## Verification
The bench targets the tie cases of the comparisons. A request at exactly the waiting priority must be refused; a design using a strict compare there would swap sources back and forth. A current-priority write exactly equal to the pending priority must cancel the waiting request; getting this wrong leaves the core interrupted below its own threshold. When an inter-processor request is displaced or cancelled, the bench expects no reject. A design that rejected it anyway would send a reject for source 2, which no source owns. The bench also checks that a resend after an EOI or a priority raise picks up a stored inter-processor priority. A design that forgot this would leave the core idle with work outstanding.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_REQ,
    OP_CPPR,
    OP_IPI,
    OP_ACCEPT,
    OP_EOI
  } op_e;
endpackage

// File: rtl/irq_presenter_decode.sv
module irq_presenter_decode
  import irq_presenter_pkg::*;
(
  input  logic req_valid_i,
  input  logic cppr_wr_i,
  input  logic ipi_wr_i,
  input  logic accept_i,
  input  logic eoi_wr_i,
  output op_e  op_o
);
  // fixed precedence; callers keep strobes exclusive
  always_comb begin
    if (accept_i)         op_o = OP_ACCEPT;
    else if (eoi_wr_i)    op_o = OP_EOI;
    else if (cppr_wr_i)   op_o = OP_CPPR;
    else if (ipi_wr_i)    op_o = OP_IPI;
    else if (req_valid_i) op_o = OP_REQ;
    else                  op_o = OP_IDLE;
  end
endmodule

// File: rtl/irq_presenter_admit.sv
module irq_presenter_admit #(
  parameter int PRIO_W = 8
) (
  input  logic              busy_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [PRIO_W-1:0] req_prio_i,
  output logic              take_o
);
  logic below_thresh, beats_pend;
  assign below_thresh = req_prio_i < cur_prio_i;
  assign beats_pend   = !busy_i || (req_prio_i < pend_prio_i);
  assign take_o       = below_thresh && beats_pend;
endmodule

// File: rtl/irq_presenter_ipi.sv
module irq_presenter_ipi #(
  parameter int PRIO_W = 8
) (
  input  logic              en_i,
  input  logic              busy_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [PRIO_W-1:0] ipi_prio_i,
  output logic              take_o
);
  logic armed, blocked;
  assign armed   = ipi_prio_i < cur_prio_i;
  assign blocked = busy_i && (pend_prio_i <= ipi_prio_i);
  assign take_o  = en_i && armed && !blocked;
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_presenter_pkg::*;
#(
  parameter int SRC_W   = 24,
  parameter int PRIO_W  = 8,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [SRC_W-1:0]        req_src_i,
  input  logic [PRIO_W-1:0]       req_prio_i,
  input  logic                    cppr_wr_i,
  input  logic [PRIO_W-1:0]       cppr_data_i,
  input  logic                    ipi_wr_i,
  input  logic [PRIO_W-1:0]       ipi_data_i,
  input  logic                    accept_i,
  input  logic                    eoi_wr_i,
  input  logic [SRC_W+PRIO_W-1:0] eoi_data_i,
  output logic [SRC_W+PRIO_W-1:0] xirr_o,
  output logic [PRIO_W-1:0]       ipi_prio_o,
  output logic                    irq_o,
  output logic                    reject_valid_o,
  output logic [SRC_W-1:0]        reject_src_o,
  output logic                    eoi_valid_o,
  output logic [SRC_W-1:0]        eoi_src_o,
  output logic                    resend_o
);
  localparam int WORD_W = SRC_W + PRIO_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  src_q;
  logic              owned_q, irq_q;
  logic              rej_v_q, eoi_v_q, resend_q;
  logic [SRC_W-1:0]  rej_src_q, eoi_src_q;

  logic [PRIO_W-1:0] cppr_d, pend_d, mfrr_d;
  logic [SRC_W-1:0]  src_d;
  logic              owned_d, irq_d;
  logic              rej_v_d, eoi_v_d, resend_d;
  logic [SRC_W-1:0]  rej_src_d, eoi_src_d;

  op_e               op;
  logic              busy, req_take, ipi_take, chk_en, resend_go;
  logic [PRIO_W-1:0] chk_ipi, chk_cur, eoi_prio;

  assign busy     = src_q != '0;
  assign eoi_prio = eoi_data_i[WORD_W-1:SRC_W];

  irq_presenter_decode i_decode (
    .req_valid_i (req_valid_i),
    .cppr_wr_i   (cppr_wr_i),
    .ipi_wr_i    (ipi_wr_i),
    .accept_i    (accept_i),
    .eoi_wr_i    (eoi_wr_i),
    .op_o        (op)
  );

  irq_presenter_admit #(.PRIO_W(PRIO_W)) i_admit (
    .busy_i      (busy),
    .cur_prio_i  (cppr_q),
    .pend_prio_i (pend_q),
    .req_prio_i  (req_prio_i),
    .take_o      (req_take)
  );

  // resend only fires while idle, so the check is shared with the IPI write
  assign resend_go = ((op == OP_CPPR) && (cppr_data_i >= cppr_q) && !busy) ||
                     ((op == OP_EOI) && !busy);
  assign chk_en    = (op == OP_IPI) || resend_go;
  assign chk_ipi   = (op == OP_IPI) ? ipi_data_i : mfrr_q;
  always_comb begin
    unique case (op)
      OP_CPPR: chk_cur = cppr_data_i;
      OP_EOI:  chk_cur = eoi_prio;
      default: chk_cur = cppr_q;
    endcase
  end

  irq_presenter_ipi #(.PRIO_W(PRIO_W)) i_ipi (
    .en_i        (chk_en),
    .busy_i      (busy),
    .cur_prio_i  (chk_cur),
    .pend_prio_i (pend_q),
    .ipi_prio_i  (chk_ipi),
    .take_o      (ipi_take)
  );

  always_comb begin
    cppr_d    = cppr_q;
    pend_d    = pend_q;
    mfrr_d    = mfrr_q;
    src_d     = src_q;
    owned_d   = owned_q;
    irq_d     = irq_q;
    rej_v_d   = 1'b0;
    rej_src_d = '0;
    eoi_v_d   = 1'b0;
    eoi_src_d = '0;
    resend_d  = resend_go;
    unique case (op)
      OP_REQ: begin
        if (req_take) begin
          if (busy && owned_q) begin
            rej_v_d   = 1'b1;
            rej_src_d = src_q;
          end
          src_d   = req_src_i;
          pend_d  = req_prio_i;
          owned_d = 1'b1;
          irq_d   = 1'b1;
        end else begin
          rej_v_d   = 1'b1;
          rej_src_d = req_src_i;
        end
      end
      OP_CPPR: begin
        cppr_d = cppr_data_i;
        if (cppr_data_i < cppr_q && busy && cppr_data_i <= pend_q) begin
          if (owned_q) begin
            rej_v_d   = 1'b1;
            rej_src_d = src_q;
          end
          src_d   = '0;
          pend_d  = PRIO_NONE;
          owned_d = 1'b0;
          irq_d   = 1'b0;
        end
      end
      OP_IPI: mfrr_d = ipi_data_i;
      OP_ACCEPT: begin
        cppr_d  = pend_q;
        src_d   = '0;
        pend_d  = PRIO_NONE;
        owned_d = 1'b0;
        irq_d   = 1'b0;
      end
      OP_EOI: begin
        cppr_d    = eoi_prio;
        eoi_v_d   = 1'b1;
        eoi_src_d = eoi_data_i[SRC_W-1:0];
      end
      default: ;
    endcase
    if (ipi_take) begin
      if (busy && owned_q) begin
        rej_v_d   = 1'b1;
        rej_src_d = src_q;
      end
      src_d   = SRC_IPI;
      pend_d  = chk_ipi;
      owned_d = 1'b0;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q    <= '0;
      pend_q    <= PRIO_NONE;
      mfrr_q    <= PRIO_NONE;
      src_q     <= '0;
      owned_q   <= 1'b0;
      irq_q     <= 1'b0;
      rej_v_q   <= 1'b0;
      rej_src_q <= '0;
      eoi_v_q   <= 1'b0;
      eoi_src_q <= '0;
      resend_q  <= 1'b0;
    end else begin
      cppr_q    <= cppr_d;
      pend_q    <= pend_d;
      mfrr_q    <= mfrr_d;
      src_q     <= src_d;
      owned_q   <= owned_d;
      irq_q     <= irq_d;
      rej_v_q   <= rej_v_d;
      rej_src_q <= rej_src_d;
      eoi_v_q   <= eoi_v_d;
      eoi_src_q <= eoi_src_d;
      resend_q  <= resend_d;
    end
  end

  assign xirr_o         = {cppr_q, src_q};
  assign ipi_prio_o     = mfrr_q;
  assign irq_o          = irq_q;
  assign reject_valid_o = rej_v_q;
  assign reject_src_o   = rej_src_q;
  assign eoi_valid_o    = eoi_v_q;
  assign eoi_src_o      = eoi_src_q;
  assign resend_o       = resend_q;

  assert_one_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({req_valid_i, cppr_wr_i, ipi_wr_i, accept_i, eoi_wr_i}) <= 1);

  assert_req_src_nonzero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> req_src_i != '0);

  assert_reject_has_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_valid_o |-> $past(req_valid_i || cppr_wr_i || ipi_wr_i));

  assert_resend_has_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resend_o |-> $past(cppr_wr_i || eoi_wr_i));

  assert_accept_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> !irq_o && xirr_o[SRC_W-1:0] == '0);

  assert_irq_tracks_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (xirr_o[SRC_W-1:0] != '0));

  assert_low_prio_rejected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_prio_i >= xirr_o[WORD_W-1:SRC_W]
    |=> reject_valid_o && reject_src_o == $past(req_src_i) && $stable(xirr_o));

  assert_ipi_taken_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ipi_wr_i && ipi_data_i < xirr_o[WORD_W-1:SRC_W] && xirr_o[SRC_W-1:0] == '0
    |=> xirr_o[SRC_W-1:0] == SRC_IPI && irq_o);

  assert_eoi_forward_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr_i |=> eoi_valid_o && eoi_src_o == $past(eoi_data_i[SRC_W-1:0]) &&
                 xirr_o[WORD_W-1:SRC_W] == $past(eoi_data_i[WORD_W-1:SRC_W]));
endmodule

// File: tb/test_irq_presenter.sv
module test_irq_presenter;
  typedef struct {
    int          kind;
    logic [23:0] src;
    int          cyc;
    string       tag;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, cppr_wr = 0, ipi_wr = 0, accept = 0, eoi_wr = 0;
  logic [23:0] req_src = '0;
  logic [7:0]  req_prio = '0, cppr_data = '0, ipi_data = '0;
  logic [31:0] eoi_data = '0;
  logic [31:0] xirr;
  logic [7:0]  ipi_prio;
  logic        irq, rej_v, eoi_v, resend;
  logic [23:0] rej_src, eoi_src;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  ev_t  exp_q[$];
  ev_t  stage_q[$];
  logic [31:0] got;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_presenter i_irq_presenter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_src_i(req_src), .req_prio_i(req_prio),
    .cppr_wr_i(cppr_wr), .cppr_data_i(cppr_data),
    .ipi_wr_i(ipi_wr), .ipi_data_i(ipi_data),
    .accept_i(accept), .eoi_wr_i(eoi_wr), .eoi_data_i(eoi_data),
    .xirr_o(xirr), .ipi_prio_o(ipi_prio), .irq_o(irq),
    .reject_valid_o(rej_v), .reject_src_o(rej_src),
    .eoi_valid_o(eoi_v), .eoi_src_o(eoi_src), .resend_o(resend)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // kind: 0 reject, 1 eoi notice, 2 resend
  task automatic expect_ev(int kind, logic [23:0] src, string tag);
    stage_q.push_back('{kind, src, 0, tag});
  endtask

  task automatic launch();
    foreach (stage_q[i]) begin
      ev_t e = stage_q[i];
      e.cyc = cyc + 1;
      exp_q.push_back(e);
    end
    stage_q.delete();
  endtask

  task automatic finish_op();
    @(negedge clk);
    req_valid = 0; cppr_wr = 0; ipi_wr = 0; accept = 0; eoi_wr = 0;
  endtask

  task automatic do_req(logic [23:0] s, logic [7:0] p);
    @(negedge clk); launch();
    req_valid = 1; req_src = s; req_prio = p;
    finish_op();
  endtask

  task automatic do_cppr(logic [7:0] v);
    @(negedge clk); launch();
    cppr_wr = 1; cppr_data = v;
    finish_op();
  endtask

  task automatic do_ipi(logic [7:0] v);
    @(negedge clk); launch();
    ipi_wr = 1; ipi_data = v;
    finish_op();
  endtask

  task automatic do_accept(output logic [31:0] r);
    @(negedge clk); launch();
    accept = 1; r = xirr;
    finish_op();
  endtask

  task automatic do_eoi(logic [31:0] w);
    @(negedge clk); launch();
    eoi_wr = 1; eoi_data = w;
    finish_op();
  endtask

  task automatic check_ev(int kind, logic [23:0] src);
    n_chk++;
    if (exp_q.size() == 0) begin
      n_fail++;
      $display("FAIL R11: unexpected event kind %0d src %06h, expected none", kind, src);
    end else if (exp_q[0].kind != kind || exp_q[0].src !== src || exp_q[0].cyc != cyc) begin
      n_fail++;
      $display("FAIL %s: actual kind %0d src %06h cyc %0d expected kind %0d src %06h cyc %0d",
               exp_q[0].tag, kind, src, cyc, exp_q[0].kind, exp_q[0].src, exp_q[0].cyc);
      void'(exp_q.pop_front());
    end else begin
      void'(exp_q.pop_front());
    end
  endtask

  // monitor: compares strobes against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: actual no event expected kind %0d src %06h at cyc %0d",
                 exp_q[0].tag, exp_q[0].kind, exp_q[0].src, exp_q[0].cyc);
        void'(exp_q.pop_front());
      end
      if (rej_v)  check_ev(0, rej_src);
      if (eoi_v)  check_ev(1, eoi_src);
      if (resend) check_ev(2, 24'h0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 word", xirr, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 ipi prio", {24'b0, ipi_prio}, 32'hFF);
    check("R1 strobes", {29'b0, rej_v, eoi_v, resend}, 32'h0);

    expect_ev(0, 24'h10, "R3 prio>=cur");
    do_req(24'h10, 8'h05);
    check("R3 word unchanged", xirr, 32'h0);

    expect_ev(2, 0, "R7 resend");
    do_cppr(8'hFF);
    check("R7 word", xirr, 32'hFF00_0000);

    do_req(24'h10, 8'h05);
    check("R4 latch", xirr, 32'hFF00_0010);
    check("R4 irq", {31'b0, irq}, 32'h1);

    expect_ev(0, 24'h20, "R3 equal pend");
    do_req(24'h20, 8'h05);
    check("R3 word kept", xirr, 32'hFF00_0010);

    expect_ev(0, 24'h10, "R4 displaced");
    do_req(24'h30, 8'h03);
    check("R4 displace", xirr, 32'hFF00_0030);

    do_accept(got);
    check("R2 returned", got, 32'hFF00_0030);
    check("R2 promoted", xirr, 32'h0300_0000);
    check("R2 irq low", {31'b0, irq}, 32'h0);

    do_accept(got);
    check("R2 second return", got, 32'h0300_0000);
    check("R2 pend reset", xirr, 32'hFF00_0000);

    do_ipi(8'h40);
    check("R5 ipi taken", xirr, 32'hFF00_0002);
    check("R5 ipi reg", {24'b0, ipi_prio}, 32'h40);
    check("R5 irq", {31'b0, irq}, 32'h1);

    do_req(24'h50, 8'h20);
    check("R4 over ipi no reject", xirr, 32'hFF00_0050);

    do_ipi(8'h30);
    check("R5 ipi blocked", xirr, 32'hFF00_0050);
    check("R5 reg updated", {24'b0, ipi_prio}, 32'h30);

    expect_ev(0, 24'h50, "R5 displaced src");
    do_ipi(8'h10);
    check("R5 ipi displaces", xirr, 32'hFF00_0002);

    do_cppr(8'h08);
    check("R6 cancel ipi", xirr, 32'h0800_0000);
    check("R6 irq low", {31'b0, irq}, 32'h0);

    expect_ev(2, 0, "R9 resend");
    do_cppr(8'hFF);
    check("R9 ipi on resend", xirr, 32'hFF00_0002);

    do_req(24'h60, 8'h05);
    check("R4 latch 60", xirr, 32'hFF00_0060);

    do_cppr(8'h40);
    check("R6 no cancel", xirr, 32'h4000_0060);
    check("R6 irq kept", {31'b0, irq}, 32'h1);

    expect_ev(0, 24'h60, "R6 cancel reject");
    do_cppr(8'h05);
    check("R6 cancel equal", xirr, 32'h0500_0000);

    expect_ev(1, 24'h77, "R8 eoi");
    expect_ev(2, 0, "R8 resend");
    do_eoi(32'hFF00_0077);
    check("R9 ipi after eoi", xirr, 32'hFF00_0002);

    do_accept(got);
    check("R2 ipi return", got, 32'hFF00_0002);
    check("R2 ipi promoted", xirr, 32'h1000_0000);

    do_ipi(8'hFF);
    check("R5 no check", xirr, 32'h1000_0000);

    expect_ev(1, 24'h02, "R8 eoi ipi");
    expect_ev(2, 0, "R8 resend idle");
    do_eoi(32'h3000_0002);
    check("R8 prio copied", xirr, 32'h3000_0000);

    do_req(24'h70, 8'h01);
    expect_ev(1, 24'h44, "R8 eoi busy");
    do_eoi(32'hFF00_0044);
    check("R8 no resend busy", xirr, 32'hFF00_0070);

    repeat (3) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule